// File: doc/BRIEF.md
# Calibration capture timer

A free-running up-counter for measuring one clock against another. Its increment tick can be taken from the system clock, from the system clock divided by twelve, or from an external clock-enable strobe divided by eight. When capture is enabled, a chosen reference event copies the live count into the reload register, so the count between two events gives the ratio of the two clocks. The reference event is either a one-cycle start-of-frame pulse from a USB interface or a falling edge of a slow oscillator. The oscillator input may be asynchronous to the system clock.

Software writes a control word through a strobe. It reads the live count and the captured count. It clears the capture flag and the overflow flag with separate pulses. One interrupt line is raised from either flag when interrupts are enabled.

Top module: `cal_capture_timer`

## Requirements
- R1: After reset, count_o, capture_o, cap_flag_o, ovf_flag_o and irq_o are all zero, and all control fields are zero.
- R2: The counter adds exactly one on each selected tick while the run bit is 1. While the run bit is 0 it holds its value.
- R3: The clock select field picks the tick. 0 (and 3) means every system clock cycle. 1 means one tick per 12 system cycles. 2 means one tick per 8 cycles in which ext_clk_en_i is high.
- R4: A tick at count 0xFFFF wraps the counter to 0x0000 and sets ovf_flag_o.
- R5: With capture enabled, a selected event copies count_o into capture_o at the next clock edge and sets cap_flag_o.
- R6: Source select 0 takes sof_i. Source select 1 takes a falling edge on lfo_i. The unselected input has no effect. With capture disabled, neither input has any effect.
- R7: lfo_i passes through a two-flop synchronizer. A single falling edge gives exactly one capture, at the third rising clock edge after the fall. A rising edge gives none.
- R8: When a capture and a tick fall in the same cycle, capture_o takes the count from before that tick.
- R9: cap_flag_o stays set until a cap_clr_i pulse and ovf_flag_o stays set until an ovf_clr_i pulse. A capture in the same cycle as cap_clr_i leaves cap_flag_o set.
- R10: irq_o is high exactly when the interrupt enable bit is 1 and either flag is set.
- R11: The control fields change only in a cycle with cfg_we_i high, and the new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_run_i | input | 1 | Run bit |
| cfg_cap_en_i | input | 1 | Capture enable |
| cfg_src_sel_i | input | 1 | Capture source: 0 start-of-frame, 1 oscillator fall |
| cfg_clk_sel_i | input | 2 | Tick select |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cap_clr_i | input | 1 | Clear capture flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| ext_clk_en_i | input | 1 | External clock enable strobe |
| sof_i | input | 1 | Start-of-frame pulse, one cycle |
| lfo_i | input | 1 | Slow oscillator, asynchronous |
| count_o | output | 16 | Live count |
| capture_o | output | 16 | Reload register holding the captured count |
| cap_flag_o | output | 1 | Capture flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a divide-by-12 system prescaler and a divide-by-8 external prescaler. At these values a full wrap takes 65,536 system cycles, which fits well within the run. The bench measures prescaled rates over windows of 120 cycles and 40 strobes. Each of these windows spans a whole number of prescaler periods, so the expected counts hold at any prescaler phase.

// File: rtl/cal_tmr_pkg.sv
package cal_tmr_pkg;
  typedef enum logic [1:0] {
    TICK_SYS  = 2'd0,
    TICK_DIV  = 2'd1,
    TICK_EXT  = 2'd2,
    TICK_RSV  = 2'd3
  } tick_sel_e;

  typedef enum logic {
    SRC_SOF = 1'b0,
    SRC_LFO = 1'b1
  } cap_src_e;
endpackage

// File: rtl/cal_tick_gen.sv
module cal_tick_gen
  import cal_tmr_pkg::*;
#(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tick_sel_e sel_i,
  input  logic      ext_en_i,
  output logic      tick_o
);
  localparam int SYS_W = (DIV_SYS > 1) ? $clog2(DIV_SYS) : 1;
  localparam int EXT_W = (DIV_EXT > 1) ? $clog2(DIV_EXT) : 1;
  localparam logic [SYS_W-1:0] SYS_LAST = SYS_W'(DIV_SYS - 1);
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(DIV_EXT - 1);

  logic [SYS_W-1:0] sys_q;
  logic [EXT_W-1:0] ext_q;
  logic sys_wrap, ext_wrap;

  assign sys_wrap = (sys_q == SYS_LAST);
  assign ext_wrap = (ext_q == EXT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_q <= '0;
    else if (sys_wrap) sys_q <= '0;
    else sys_q <= sys_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else if (ext_en_i) ext_q <= ext_wrap ? '0 : ext_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      TICK_DIV: tick_o = sys_wrap;
      TICK_EXT: tick_o = ext_en_i & ext_wrap;
      default:  tick_o = 1'b1;
    endcase
  end

  p_sys_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_q <= SYS_LAST);
  p_ext_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |=> $stable(ext_q));
endmodule

// File: rtl/cal_lfo_edge.sv
module cal_lfo_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lfo_i,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-1:0], lfo_i};
  end

  // history bit high, newest synchronized bit low
  assign fall_o = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];

  p_fall_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cal_count_reg.sv
module cal_count_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cap_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] rld_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic step;
  assign step   = run_i & tick_i;
  assign wrap_o = step & (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (step) cnt_o <= cnt_o + 1'b1;
  end

  // captures the pre-tick value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rld_o <= '0;
    else if (cap_i) rld_o <= cnt_o;
  end

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) |=> $stable(cnt_o));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> cnt_o == WIDTH'($past(cnt_o) + 1'b1));
  p_capture_pre_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> rld_o == $past(cnt_o));
  p_rld_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rld_o));
endmodule

// File: rtl/cal_capture_timer.sv
module cal_capture_timer
  import cal_tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIV_SYS     = 12,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_run_i,
  input  logic             cfg_cap_en_i,
  input  logic             cfg_src_sel_i,
  input  logic [1:0]       cfg_clk_sel_i,
  input  logic             cfg_irq_en_i,
  input  logic             cap_clr_i,
  input  logic             ovf_clr_i,
  input  logic             ext_clk_en_i,
  input  logic             sof_i,
  input  logic             lfo_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic             cap_flag_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  logic      run_q, cap_en_q, irq_en_q;
  cap_src_e  src_q;
  tick_sel_e tsel_q;
  logic      tick, lfo_fall, cap_stb, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cap_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      src_q    <= SRC_SOF;
      tsel_q   <= TICK_SYS;
    end else if (cfg_we_i) begin
      run_q    <= cfg_run_i;
      cap_en_q <= cfg_cap_en_i;
      irq_en_q <= cfg_irq_en_i;
      src_q    <= cap_src_e'(cfg_src_sel_i);
      tsel_q   <= tick_sel_e'(cfg_clk_sel_i);
    end
  end

  cal_tick_gen #(.DIV_SYS(DIV_SYS), .DIV_EXT(DIV_EXT)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (tsel_q),
    .ext_en_i(ext_clk_en_i),
    .tick_o  (tick)
  );

  cal_lfo_edge #(.SYNC_STAGES(SYNC_STAGES)) u_lfo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lfo_i (lfo_i),
    .fall_o(lfo_fall)
  );

  assign cap_stb = cap_en_q & ((src_q == SRC_LFO) ? lfo_fall : sof_i);

  cal_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .tick_i(tick),
    .cap_i (cap_stb),
    .cnt_o (count_o),
    .rld_o (capture_o),
    .wrap_o(wrap)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_flag_o <= 1'b0;
      ovf_flag_o <= 1'b0;
    end else begin
      if (cap_stb) cap_flag_o <= 1'b1;
      else if (cap_clr_i) cap_flag_o <= 1'b0;
      if (wrap) ovf_flag_o <= 1'b1;
      else if (ovf_clr_i) ovf_flag_o <= 1'b0;
    end
  end

  assign irq_o = irq_en_q & (cap_flag_o | ovf_flag_o);

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (count_o == '0) && ovf_flag_o);
  p_cap_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb |=> cap_flag_o);
  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o && !cap_clr_i) |=> cap_flag_o);
  p_ovf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);
  p_cfg_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(run_q) && $stable(cap_en_q) && $stable(tsel_q));
endmodule

// File: tb/cal_capture_timer_bench.sv
module cal_capture_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_run = 0, cfg_cap = 0, cfg_src = 0, cfg_irq = 0;
  logic [1:0] cfg_clk = 2'd0;
  logic cap_clr = 0, ovf_clr = 0, ext_en = 0, sof = 0, lfo = 0;
  logic [15:0] count, capture;
  logic cap_flag, ovf_flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cal_capture_timer u_cal_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_run_i(cfg_run),
    .cfg_cap_en_i(cfg_cap), .cfg_src_sel_i(cfg_src), .cfg_clk_sel_i(cfg_clk),
    .cfg_irq_en_i(cfg_irq), .cap_clr_i(cap_clr), .ovf_clr_i(ovf_clr),
    .ext_clk_en_i(ext_en), .sof_i(sof), .lfo_i(lfo), .count_o(count),
    .capture_o(capture), .cap_flag_o(cap_flag), .ovf_flag_o(ovf_flag), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic run, logic cap, logic src, logic [1:0] cs, logic ie);
    cfg_we = 1; cfg_run = run; cfg_cap = cap; cfg_src = src; cfg_clk = cs; cfg_irq = ie;
    cyc(1);
    cfg_we = 0; cfg_run = 0; cfg_cap = 0; cfg_src = 0; cfg_clk = 0; cfg_irq = 0;
  endtask

  task automatic clr_flags();
    cap_clr = 1; ovf_clr = 1; cyc(1); cap_clr = 0; ovf_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 flags/irq", {cap_flag, ovf_flag, irq}, 0);
    cyc(5);
    chk("R1 idle count", count, 0);
  endtask

  task automatic t_run_hold();
    logic [15:0] c0;
    cfg(1, 0, 0, 2'd0, 0);
    c0 = count; cyc(10);
    chk("R2 sysclk step", count, c0 + 16'd10);
    cfg(0, 0, 0, 2'd0, 0);
    c0 = count; cyc(7);
    chk("R2 hold when stopped", count, c0);
    cfg_run = 1; cyc(3); cfg_run = 0;
    chk("R11 run ignored without strobe", count, c0);
  endtask

  task automatic t_prescale();
    logic [15:0] c0;
    cfg(1, 0, 0, 2'd1, 0);
    c0 = count; cyc(120);
    chk("R3 div12 rate", count, c0 + 16'd10);
    cfg(1, 0, 0, 2'd2, 0);
    c0 = count; cyc(20);
    chk("R3 ext idle", count, c0);
    for (int i = 0; i < 40; i++) begin
      ext_en = 1; cyc(1); ext_en = 0; cyc(2);
    end
    chk("R3 ext div8 rate", count, c0 + 16'd5);
  endtask

  task automatic t_sof_capture();
    logic [15:0] v;
    cfg(1, 1, 0, 2'd0, 0);
    clr_flags();
    v = count; sof = 1; cyc(1); sof = 0;
    chk("R8 pre-tick capture", capture, v);
    chk("R2 tick during capture", count, v + 16'd1);
    chk("R5 cap flag set", cap_flag, 1);
    chk("R10 irq masked", irq, 0);
    cfg(1, 1, 0, 2'd0, 1);
    chk("R10 irq enabled", irq, 1);
    cap_clr = 1; cyc(1); cap_clr = 0;
    chk("R9 flag cleared", cap_flag, 0);
    chk("R10 irq drops", irq, 0);
    cyc(3);
    cap_clr = 1; sof = 1; cyc(1); cap_clr = 0; sof = 0;
    chk("R9 capture beats clear", cap_flag, 1);
    clr_flags();
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    cfg(1, 1, 1, 2'd0, 0);
    v = capture;
    cyc(2); sof = 1; cyc(1); sof = 0; cyc(2);
    chk("R6 sof ignored with lfo source", capture, v);
    chk("R6 flag untouched", cap_flag, 0);
    cfg(1, 0, 0, 2'd0, 0);
    cyc(2); sof = 1; cyc(1); sof = 0; cyc(2);
    chk("R6 capture disabled", capture, v);
    chk("R6 flag untouched off", cap_flag, 0);
  endtask

  task automatic t_lfo();
    logic [15:0] old, w;
    cfg(1, 1, 1, 2'd0, 0);
    lfo = 1; cyc(6);
    chk("R7 rising edge no capture", cap_flag, 0);
    cfg(0, 1, 1, 2'd0, 0);
    old = capture; w = count;
    lfo = 0; cyc(2);
    chk("R7 not yet captured", capture, old);
    chk("R7 flag not yet set", cap_flag, 0);
    cyc(1);
    chk("R7 captured third edge", capture, w);
    chk("R7 flag set", cap_flag, 1);
    cap_clr = 1; cyc(1); cap_clr = 0; cyc(6);
    chk("R7 single strobe", cap_flag, 0);
    lfo = 1; cyc(6);
    chk("R7 rise ignored", cap_flag, 0);
    lfo = 0; cyc(6);
    clr_flags();
  endtask

  task automatic t_wrap();
    int guard = 0;
    cfg(1, 0, 0, 2'd0, 0);
    chk("R4 no early ovf", ovf_flag, 0);
    while (count != 16'hFFFF && guard < 70000) begin
      cyc(1); guard++;
    end
    chk("R4 reached max", count, 16'hFFFF);
    cyc(1);
    chk("R4 wrap to zero", count, 0);
    chk("R4 ovf flag", ovf_flag, 1);
    cfg(1, 0, 0, 2'd0, 1);
    chk("R10 irq from ovf", irq, 1);
    cyc(3);
    chk("R9 ovf held", ovf_flag, 1);
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    chk("R9 ovf cleared", ovf_flag, 0);
  endtask

  initial begin
    #1000000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_reset();
    t_run_hold();
    t_prescale();
    t_sof_capture();
    t_ignored();
    t_lfo();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule